// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches the input pins of one eight-pin port and merges their interrupt events into one GPIO request line for the CPU. Each pad input first passes through a synchroniser. Each pin then has its own event type and enable bit. The event type is held in two bit-plane registers, where bit n of each plane belongs to pin n. A pin can fire on a falling edge or a rising edge. It can also fire on a change relative to the value that software saw at its last read of the pin data register.

Every event lands in one sticky pending flag. Software reads this flag at a fixed bit of a posted register. It clears the flag or posts it through the same register, and the meaning of a write depends on a separate software-post enable. A global mask bit decides whether the pending flag reaches the CPU. All registers sit behind a small register bus. Pins whose digital input is switched off (analog use) never raise events.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, the pending flag is clear and `irq_to_cpu` is low.
- R2: The event type of pin n is {tsel_hi[n], tsel_lo[n]}. The value 00 gives no event, 01 fires on a 1-to-0 transition of the synchronised pin and 10 fires on a 0-to-1 transition.
- R3: Type 11 fires while the synchronised pin differs from the value captured at the last read of the pin data register. A read of that register (address 0) returns the synchronised pins and captures them, which rearms the comparison. The capture resets to 0.
- R4: A pin whose bit in the enable register (address 1) is 0 raises no event.
- R5: Any event on any pin sets the pending flag. The flag stays set after the cause goes away, until software clears it.
- R6: With the software-post enable (address 6, bit 0) at 0, writing 0 to bit 5 of the posted register (address 5) clears the pending flag, and writing 1 there leaves it unchanged.
- R7: With the software-post enable at 1, writing 1 to bit 5 of the posted register sets the pending flag, and writing 0 there leaves it unchanged.
- R8: `irq_to_cpu` is high exactly when, one cycle earlier, the pending flag was set and bit 5 of the mask register (address 4) was 1.
- R9: A pin whose `pin_dig_off` bit is 1 never raises an event, and it reads as 0 in the pin data register.
- R10: A pad change is seen by the pending flag at the third rising edge after it, and on `irq_to_cpu` at the fourth. If an event and a software clear arrive in the same cycle, the event wins.
- R11: Reads are registered, so `reg_rdata` holds the addressed value from the edge after `reg_rd` onward. Bit 5 of the posted register reads the pending flag, and unused addresses read 0. The type planes sit at addresses 2 (tsel_lo) and 3 (tsel_hi).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 8 | Asynchronous pad input levels |
| pin_dig_off | input | 8 | Per-pin digital input disable (analog use) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_to_cpu | output | 1 | Masked GPIO interrupt request |

## Verification
A pad change reaches the pending flag three rising edges later: two synchroniser flops, then the flag itself. It reaches `irq_to_cpu` one edge after that. Register reads show up on `reg_rdata` at the edge that samples `reg_rd`. The bench drives every input on the falling edge and samples there as well. It waits at least five cycles after a pad change before it reads the posted register. The latency test checks `irq_to_cpu` on each of the four falling edges after the change. The same-cycle test raises the clear strobe on the exact edge where the event is sampled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PINS = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_THI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] A_POST = 3'd5;
  localparam logic [ADDR_W-1:0] A_SWEN = 3'd6;

  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_FALL   = 2'b01,
    EV_RISE   = 2'b10,
    EV_CHANGE = 2'b11
  } evt_kind_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] last_rd,
  input  logic [W-1:0] en,
  input  logic [W-1:0] tsel_lo,
  input  logic [W-1:0] tsel_hi,
  input  logic [W-1:0] dig_off,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins;
  end

  genvar n;
  generate
    for (n = 0; n < W; n++) begin : g_pin
      evt_kind_e kind;
      logic      hit;
      assign kind = evt_kind_e'({tsel_hi[n], tsel_lo[n]});
      always_comb begin
        unique case (kind)
          EV_FALL:   hit = prev_q[n] & ~pins[n];
          EV_RISE:   hit = ~prev_q[n] & pins[n];
          EV_CHANGE: hit = pins[n] ^ last_rd[n];
          default:   hit = 1'b0;
        endcase
      end
      assign evt[n] = hit & en[n] & ~dig_off[n];
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W        = 8,
  parameter int GPIO_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pins,
  input  logic [W-1:0]      dig_off,
  input  logic              pend,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      tlo_q,
  output logic [W-1:0]      thi_q,
  output logic [W-1:0]      last_rd_q,
  output logic              mask_on,
  output logic              sw_en,
  output logic              sw_clr,
  output logic              sw_set
);
  logic [W-1:0] mask_q;
  logic         swen_q;
  logic [W-1:0] pins_vis;
  logic [W-1:0] rd_mux;
  logic         post_wr;

  assign pins_vis = pins & ~dig_off;
  assign post_wr  = reg_wr && (reg_addr == A_POST);
  assign sw_clr   = post_wr && !swen_q && !reg_wdata[GPIO_BIT];
  assign sw_set   = post_wr &&  swen_q &&  reg_wdata[GPIO_BIT];
  assign mask_on  = mask_q[GPIO_BIT];
  assign sw_en    = swen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      tlo_q  <= '0;
      thi_q  <= '0;
      mask_q <= '0;
      swen_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN:    en_q   <= reg_wdata;
        A_TLO:   tlo_q  <= reg_wdata;
        A_THI:   thi_q  <= reg_wdata;
        A_MASK:  mask_q <= reg_wdata;
        A_SWEN:  swen_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_PINS: rd_mux = pins_vis;
      A_EN:   rd_mux = en_q;
      A_TLO:  rd_mux = tlo_q;
      A_THI:  rd_mux = thi_q;
      A_MASK: rd_mux = mask_q;
      A_POST: rd_mux[GPIO_BIT] = pend;
      A_SWEN: rd_mux[0] = swen_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      last_rd_q <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
      if (reg_addr == A_PINS) last_rd_q <= pins_vis;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int GPIO_BIT    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] pin_dig_off,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  output logic                irq_to_cpu
);
  logic [NUM_PINS-1:0] pins_s;
  logic [NUM_PINS-1:0] en_q, tlo_q, thi_q, last_rd_q;
  logic [NUM_PINS-1:0] evt_vec;
  logic                mask_on, sw_en, sw_clr, sw_set;
  logic                pending_q;
  logic                irq_q;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pins_s)
  );

  gpio_irq_regs #(.W(NUM_PINS), .GPIO_BIT(GPIO_BIT)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pins(pins_s), .dig_off(pin_dig_off), .pend(pending_q),
    .en_q(en_q), .tlo_q(tlo_q), .thi_q(thi_q), .last_rd_q(last_rd_q),
    .mask_on(mask_on), .sw_en(sw_en), .sw_clr(sw_clr), .sw_set(sw_set)
  );

  gpio_irq_detect #(.W(NUM_PINS)) det_i (
    .clk(clk), .rst(rst), .pins(pins_s), .last_rd(last_rd_q),
    .en(en_q), .tsel_lo(tlo_q), .tsel_hi(thi_q), .dig_off(pin_dig_off),
    .evt(evt_vec)
  );

  // Event sets take priority over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= (pending_q & ~sw_clr) | (|evt_vec) | sw_set;
      irq_q     <= pending_q & mask_on;
    end
  end

  assign irq_to_cpu = irq_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int W        = 8,
  parameter int GPIO_BIT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic              irq_to_cpu,
  input logic              pend,
  input logic              mask_on,
  input logic              sw_en,
  input logic [W-1:0]      evt,
  input logic [W-1:0]      dig_off
);
  logic post_wr;
  assign post_wr = reg_wr && (reg_addr == A_POST);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq_to_cpu |-> $past(mask_on && pend));

  p_pend_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !(post_wr && !sw_en && !reg_wdata[GPIO_BIT])) |=> pend);

  p_evt_posts_r10: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> pend);

  p_one_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!pend && post_wr && !sw_en && evt == '0) |=> !pend);

  p_sw_post_r7: assert property (@(posedge clk) disable iff (rst)
    (post_wr && sw_en && reg_wdata[GPIO_BIT]) |=> pend);

  p_analog_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (evt & dig_off) == '0);

  p_post_read_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_POST) |=> reg_rdata[GPIO_BIT] == $past(pend));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.W(NUM_PINS), .GPIO_BIT(GPIO_BIT)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_to_cpu(irq_to_cpu), .pend(pending_q), .mask_on(mask_on),
  .sw_en(sw_en), .evt(evt_vec), .dig_off(pin_dig_off)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pad_in = '0;
  logic [7:0] pin_dig_off = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_to_cpu;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pin_dig_off(pin_dig_off),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_to_cpu(irq_to_cpu)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_pend();
    bus_wr(3'd6, 8'h00);
    bus_wr(3'd5, 8'h00);
  endtask

  function automatic bit exp_evt(input bit hi, input bit lo, input bit o,
                                 input bit nw, input bit lr);
    case ({hi, lo})
      2'b01:   return o & ~nw;
      2'b10:   return ~o & nw;
      2'b11:   return nw != lr;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    settle(4);
    rst = 1'b0;
    settle(1);

    // R1: reset state
    check(irq_to_cpu == 1'b0, "R1 irq", irq_to_cpu, 0);
    for (int a = 0; a < 8; a++) begin
      bus_rd(a[2:0], d);
      check(d == 8'h00, "R1 reg", d, 0);
    end

    // R10 / R8: latency of a rising edge on pin 2
    bus_wr(3'd1, 8'h04);
    bus_wr(3'd3, 8'h04);
    bus_wr(3'd4, 8'h20);
    @(negedge clk); pad_in = 8'h04;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(irq_to_cpu == (k == 4), "R10 latency", irq_to_cpu, k == 4);
    end
    bus_rd(3'd5, d);
    check(d == 8'h20, "R11 posted read", d, 8'h20);

    // R5: sticky after pin returns; falling edge type 01 unused here
    pad_in = 8'h00; settle(6);
    bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R5 sticky", d[5], 1);

    // R8: mask off drops irq while pending remains
    bus_wr(3'd4, 8'hDF); settle(2);
    check(irq_to_cpu == 1'b0, "R8 masked", irq_to_cpu, 0);

    // R6: sw_en=0, write 1 no effect, write 0 clears
    bus_wr(3'd5, 8'h20); bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R6 write1 ignored", d[5], 1);
    bus_wr(3'd5, 8'h00); bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R6 clear", d[5], 0);

    // R7: sw_en=1, write 0 no effect on clear flag, write 1 posts
    bus_wr(3'd6, 8'h01);
    bus_wr(3'd5, 8'h00); bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R7 write0 ignored", d[5], 0);
    bus_wr(3'd5, 8'h20); bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R7 post", d[5], 1);
    bus_wr(3'd5, 8'h00); bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R7 write0 keeps", d[5], 1);
    clr_pend();

    // R10: event and clear in the same cycle, event wins
    @(negedge clk); pad_in = 8'h04;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 1'b0;
    bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R10 event beats clear", d[5], 1);
    pad_in = 8'h00; settle(4); clr_pend();

    // R3: change-from-read on pin 0, rearm by read
    bus_wr(3'd2, 8'h01); bus_wr(3'd3, 8'h01); bus_wr(3'd1, 8'h01);
    settle(2); bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R3 quiet when equal", d[5], 0);
    pad_in = 8'h01; settle(5); bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R3 change fires", d[5], 1);
    clr_pend(); bus_rd(3'd5, d);
    check(d[5] == 1'b1, "R3 still differs", d[5], 1);
    bus_rd(3'd0, d);
    check(d == 8'h01, "R3 data read", d, 1);
    clr_pend(); bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R3 rearmed", d[5], 0);

    // R9: analog pin reads 0 and raises nothing
    pin_dig_off = 8'h01; pad_in = 8'h00; settle(5);
    bus_rd(3'd0, d);
    check(d == 8'h00, "R9 read zero", d, 0);
    bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R9 no event", d[5], 0);
    pin_dig_off = 8'h00; bus_rd(3'd0, d); clr_pend();

    // R4: disabled pin raises nothing
    bus_wr(3'd1, 8'h00); bus_wr(3'd3, 8'h02); bus_wr(3'd2, 8'h00);
    pad_in = 8'h02; settle(5); bus_rd(3'd5, d);
    check(d[5] == 1'b0, "R4 disabled", d[5], 0);
    pad_in = 8'h00; settle(4);

    // R2 / R3 / R8 / R9 random trials
    for (int t = 0; t < 60; t++) begin
      logic [7:0] o, nw, en, lo, hi, dg, mk, lr;
      bit e;
      o = 8'($urandom); nw = 8'($urandom); en = 8'($urandom);
      lo = 8'($urandom); hi = 8'($urandom); dg = 8'($urandom) & 8'($urandom);
      mk = 8'($urandom);
      if (t % 4 == 0) nw = o;
      bus_wr(3'd1, 8'h00);
      pad_in = o; pin_dig_off = dg; settle(4);
      bus_wr(3'd2, lo); bus_wr(3'd3, hi); bus_wr(3'd4, mk);
      bus_rd(3'd0, d);
      lr = o & ~dg;
      check(d == lr, "R3 capture read", d, lr);
      bus_wr(3'd1, en);
      clr_pend();
      @(negedge clk); pad_in = nw;
      settle(5);
      e = 1'b0;
      for (int n = 0; n < 8; n++)
        if (en[n] && !dg[n]) e |= exp_evt(hi[n], lo[n], o[n], nw[n], lr[n]);
      bus_rd(3'd5, d);
      check(d[5] == e, "R2 random pending", d[5], e);
      check(irq_to_cpu == (e & mk[5]), "R8 random irq", irq_to_cpu, e & mk[5]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule